// File: doc/BRIEF.md
# Multi-Mode 64-bit Alarm Timer Group

This block holds a group of general-purpose timers, two by default, behind a simple synchronous register bus. Each timer has a 64-bit counter that counts up or down. The counter advances once per tick of its own prescaler, and the prescaler is set by a 16-bit divider. The count is not read directly. Software first writes a strobe that captures the live count into a pair of 32-bit snapshot registers, and then reads those registers at leisure. A new count is staged as two 32-bit halves, and it reaches the counter only when a separate commit strobe is written.

Each timer also has a 64-bit alarm comparator. Software arms the alarm with a control bit. The alarm fires once the count has reached the alarm value in the current counting direction, and on firing the arm bit clears itself. If auto-reload is on, the event also copies the staged load value back into the counter. The group keeps one pending bit per timer, one interrupt-enable bit per timer and a write-one-to-clear register. From these it drives one shared level interrupt line and one single-cycle edge interrupt pulse.

The bus carries only register traffic, so it uses plain write and read strobes without valid/ready handshaking and never applies back-pressure. A write takes effect at the clock edge where `bus_wr` is sampled high. A read returns its data one cycle after `bus_rd`.

Register layout. The top bit of the address selects the group registers. Below that, address bits [6:4] select the timer and bits [3:0] select the register within it:

| Offset | Timer register |
|---|---|
| 0x0 | control |
| 0x1 | snapshot low (read) |
| 0x2 | snapshot high (read) |
| 0x3 | snapshot strobe (write) |
| 0x4 | load low |
| 0x5 | load high |
| 0x6 | load commit strobe (write) |
| 0x7 | alarm low |
| 0x8 | alarm high |

Group registers:

| Address | Group register |
|---|---|
| 0x80 | interrupt enable |
| 0x81 | raw pending |
| 0x82 | masked pending |
| 0x83 | clear (write-one) |

Control fields: bit0 run, bit1 count up (0 = down), bit2 auto-reload, bit3 alarm armed, bit4 level interrupt enable, bit5 edge interrupt enable, bits[31:16] divider.

Top module: `alarm_timer_group`

## Requirements
- R1: The 64-bit counter changes only on a prescaler tick, a load commit or an auto-reload. On a tick it steps by +1 when control bit1 is 1 and by -1 when bit1 is 0. No tick occurs while control bit0 (run) is 0.
- R2: While running, a tick occurs once every N clocks. N is the divider in control bits[31:16], except that a divider of 0 means 65536 and a divider of 1 means 2.
- R3: Writes to load low (0x4) and load high (0x5) do not change the counter. Writing the commit strobe (0x6) copies {high, low} into the counter. Each timer's registers are independent of the other timers'.
- R4: Writing the snapshot strobe (0x3) copies the live counter into snapshot low (0x1) and snapshot high (0x2). The snapshot holds its value until the next strobe, and it reads 0 after reset.
- R5: An alarm event occurs while control bit3 (armed) is 1 and the counter is greater than or equal to the alarm value when counting up, or less than or equal to it when counting down. No event occurs before that.
- R6: An alarm event clears the armed bit, so each arming yields exactly one event.
- R7: With control bit2 (auto-reload) set, an alarm event loads the staged load value into the counter. With bit2 clear, the counter is left unchanged.
- R8: An alarm event sets the timer's bit (bit i for timer i) in the raw pending register 0x81. Writing 1 to that bit of 0x83 clears it. The masked register 0x82 equals raw AND the enable register 0x80.
- R9: `level_irq` is high whenever some timer has masked pending set and its control bit4 set. `edge_irq` is a one-cycle pulse in the cycle after an event of a timer whose control bit5 and enable bit are set.
- R10: Writing a different divider while the timer is running restarts the prescaler, so the next tick comes a full new period after the write.
- R11: Read data appears on `bus_rdata` in the cycle after `bus_rd`, and the value reflects the state before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| level_irq | output | 1 | Shared level interrupt |
| edge_irq | output | 1 | Shared one-cycle edge interrupt |

## Verification
The assertions check on every clock cycle that:
- the counter holds unless it ticks, loads or reloads, and that a tick steps it by exactly one in the chosen direction;
- a commit lands the staged value;
- the snapshot stays frozen between strobes;
- the arm bit drops after an event;
- the edge output never lasts two cycles;
- the prescaler phase stays inside the current divider.

Other behaviour can only be shown by the bench's scenarios:
- the exact tick periods for the special dividers 0 and 1 and for a divider change in mid-count;
- the comparison in each counting direction;
- that auto-reload takes the staged value rather than the committed one;
- the independence of the two timers.

// File: rtl/agt_pkg.sv
package agt_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned OFS_W = 4;

  localparam logic [OFS_W-1:0] OFS_CTRL    = 4'h0;
  localparam logic [OFS_W-1:0] OFS_SNAP_LO = 4'h1;
  localparam logic [OFS_W-1:0] OFS_SNAP_HI = 4'h2;
  localparam logic [OFS_W-1:0] OFS_SNAP_GO = 4'h3;
  localparam logic [OFS_W-1:0] OFS_LOAD_LO = 4'h4;
  localparam logic [OFS_W-1:0] OFS_LOAD_HI = 4'h5;
  localparam logic [OFS_W-1:0] OFS_LOAD_GO = 4'h6;
  localparam logic [OFS_W-1:0] OFS_ALM_LO  = 4'h7;
  localparam logic [OFS_W-1:0] OFS_ALM_HI  = 4'h8;

  localparam logic [OFS_W-1:0] GRP_IEN = 4'h0;
  localparam logic [OFS_W-1:0] GRP_RAW = 4'h1;
  localparam logic [OFS_W-1:0] GRP_MSK = 4'h2;
  localparam logic [OFS_W-1:0] GRP_CLR = 4'h3;

  typedef struct packed {
    logic [15:0] div;
    logic [9:0]  rsvd;
    logic        edge_en;
    logic        level_en;
    logic        arm;
    logic        autoreload;
    logic        up;
    logic        run;
  } ctrl_t;
endpackage

// File: rtl/agt_prescale.sv
module agt_prescale #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int unsigned PC_W = DIV_W + 1;

  logic [PC_W-1:0] pcnt;
  logic [PC_W-1:0] limit;

  always_comb begin
    if (div == '0)      limit = {1'b0, {DIV_W{1'b1}}};
    else if (div == 1)  limit = PC_W'(1);
    else                limit = {1'b0, div} - PC_W'(1);
  end

  assign tick = run && !restart && (pcnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     pcnt <= '0;
    else if (!run || restart || tick) pcnt <= '0;
    else                            pcnt <= pcnt + PC_W'(1);
  end

  // R2: the phase never runs past the current period
  assert_phase_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= limit);
endmodule

// File: rtl/agt_core.sv
module agt_core
  import agt_pkg::*;
#(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [OFS_W-1:0] ofs,
  input  logic [REG_W-1:0] wdata,
  output ctrl_t            ctrl_o,
  output logic [CNT_W-1:0] snap_o,
  output logic [CNT_W-1:0] load_o,
  output logic [CNT_W-1:0] alarm_o,
  output logic             evt_o
);
  localparam int unsigned HALF = CNT_W / 2;

  ctrl_t            ctrl;
  logic [CNT_W-1:0] cnt, load_r, alarm_r, snap;
  logic             wr_ctrl, load_go, snap_go, restart, tick, reached, evt;

  assign wr_ctrl = wr && (ofs == OFS_CTRL);
  assign load_go = wr && (ofs == OFS_LOAD_GO);
  assign snap_go = wr && (ofs == OFS_SNAP_GO);
  assign restart = wr_ctrl && (wdata[31:16] != ctrl.div);

  agt_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .restart(restart),
    .div(ctrl.div), .tick(tick)
  );

  assign reached = ctrl.up ? (cnt >= alarm_r) : (cnt <= alarm_r);
  assign evt     = ctrl.arm && reached;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      load_r  <= '0;
      alarm_r <= '0;
    end else begin
      if (wr_ctrl)  ctrl     <= ctrl_t'(wdata);
      else if (evt) ctrl.arm <= 1'b0;
      if (wr && ofs == OFS_LOAD_LO) load_r[HALF-1:0]      <= wdata[HALF-1:0];
      if (wr && ofs == OFS_LOAD_HI) load_r[CNT_W-1:HALF]  <= wdata[HALF-1:0];
      if (wr && ofs == OFS_ALM_LO)  alarm_r[HALF-1:0]     <= wdata[HALF-1:0];
      if (wr && ofs == OFS_ALM_HI)  alarm_r[CNT_W-1:HALF] <= wdata[HALF-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt <= '0;
    else if (load_go)                 cnt <= load_r;
    else if (evt && ctrl.autoreload)  cnt <= load_r;
    else if (tick)                    cnt <= ctrl.up ? cnt + CNT_W'(1) : cnt - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       snap <= '0;
    else if (snap_go) snap <= cnt;
  end

  assign ctrl_o  = ctrl;
  assign snap_o  = snap;
  assign load_o  = load_r;
  assign alarm_o = alarm_r;
  assign evt_o   = evt;

  assert_cnt_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load_go && !evt) |=> $stable(cnt));
  assert_cnt_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load_go && !evt) |=>
      cnt == ($past(ctrl.up) ? $past(cnt) + CNT_W'(1) : $past(cnt) - CNT_W'(1)));
  assert_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_go |=> cnt == $past(load_r));
  assert_snap_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_go |=> $stable(snap));
  assert_arm_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !wr_ctrl) |=> !ctrl.arm);
endmodule

// File: rtl/alarm_timer_group.sv
module alarm_timer_group
  import agt_pkg::*;
#(
  parameter int unsigned NT     = 2,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              level_irq,
  output logic              edge_irq
);
  localparam int unsigned TIDX_W = ADDR_W - 1 - OFS_W;
  localparam int unsigned HALF   = CNT_W / 2;

  logic              grp_sel;
  logic [TIDX_W-1:0] tidx;
  logic [OFS_W-1:0]  ofs;
  logic [NT-1:0]     evt, int_en, raw, masked, clr_mask, lvl_vec, edg_vec;
  ctrl_t             ctrl_a  [NT];
  logic [CNT_W-1:0]  snap_a  [NT];
  logic [CNT_W-1:0]  load_a  [NT];
  logic [CNT_W-1:0]  alarm_a [NT];
  logic [31:0]       rd_mux;

  assign grp_sel = bus_addr[ADDR_W-1];
  assign tidx    = bus_addr[ADDR_W-2:OFS_W];
  assign ofs     = bus_addr[OFS_W-1:0];

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    logic t_wr;
    assign t_wr = bus_wr && !grp_sel && (tidx == TIDX_W'(i));
    agt_core #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_core (
      .clk(clk), .rst_n(rst_n), .wr(t_wr), .ofs(ofs), .wdata(bus_wdata),
      .ctrl_o(ctrl_a[i]), .snap_o(snap_a[i]), .load_o(load_a[i]),
      .alarm_o(alarm_a[i]), .evt_o(evt[i])
    );
    assign lvl_vec[i] = ctrl_a[i].level_en;
    assign edg_vec[i] = ctrl_a[i].edge_en;
  end

  assign clr_mask = (bus_wr && grp_sel && ofs == GRP_CLR) ? bus_wdata[NT-1:0] : '0;
  assign masked   = raw & int_en;
  assign level_irq = |(masked & lvl_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_en   <= '0;
      raw      <= '0;
      edge_irq <= 1'b0;
    end else begin
      if (bus_wr && grp_sel && ofs == GRP_IEN) int_en <= bus_wdata[NT-1:0];
      raw      <= (raw & ~clr_mask) | evt;
      edge_irq <= |(evt & edg_vec & int_en);
    end
  end

  always_comb begin
    rd_mux = '0;
    if (grp_sel) begin
      case (ofs)
        GRP_IEN: rd_mux = 32'(int_en);
        GRP_RAW: rd_mux = 32'(raw);
        GRP_MSK: rd_mux = 32'(masked);
        default: rd_mux = '0;
      endcase
    end else begin
      for (int i = 0; i < NT; i++) begin
        if (tidx == TIDX_W'(i)) begin
          case (ofs)
            OFS_CTRL:    rd_mux = ctrl_a[i];
            OFS_SNAP_LO: rd_mux = snap_a[i][HALF-1:0];
            OFS_SNAP_HI: rd_mux = snap_a[i][CNT_W-1:HALF];
            OFS_LOAD_LO: rd_mux = load_a[i][HALF-1:0];
            OFS_LOAD_HI: rd_mux = load_a[i][CNT_W-1:HALF];
            OFS_ALM_LO:  rd_mux = alarm_a[i][HALF-1:0];
            OFS_ALM_HI:  rd_mux = alarm_a[i][CNT_W-1:HALF];
            default:     rd_mux = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assert_clear_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((&clr_mask) && evt == '0) |=> raw == '0);
  assert_level_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    level_irq |-> (masked != '0));
  assert_edge_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    edge_irq |=> !edge_irq);
endmodule

// File: tb/alarm_timer_group_test.sv
module alarm_timer_group_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        level_irq, edge_irq;
  int          n_vec = 0, n_bad = 0;

  always #5 clk = ~clk;

  alarm_timer_group uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .level_irq(level_irq), .edge_irq(edge_irq)
  );

  // kind: 0 write, 1 read+check, 2 read without check
  typedef struct packed {
    logic [1:0]  kind;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 8'h01, 32'h0,        8'd4},  // R4 snapshot reset value
    '{2'd1, 8'h00, 32'h0,        8'd1},  // R1 control reset value
    '{2'd0, 8'h04, 32'h89ABCDEF, 8'd3},
    '{2'd0, 8'h05, 32'h01234567, 8'd3},
    '{2'd0, 8'h03, 32'h0,        8'd4},
    '{2'd1, 8'h01, 32'h0,        8'd3},  // R3 staged halves not yet in counter
    '{2'd0, 8'h06, 32'h0,        8'd3},
    '{2'd1, 8'h01, 32'h0,        8'd4},  // R4 snapshot held without strobe
    '{2'd0, 8'h03, 32'h0,        8'd4},
    '{2'd1, 8'h01, 32'h89ABCDEF, 8'd3},  // R3 commit landed
    '{2'd1, 8'h02, 32'h01234567, 8'd3},
    '{2'd0, 8'h14, 32'h00000055, 8'd3},
    '{2'd0, 8'h16, 32'h0,        8'd3},
    '{2'd0, 8'h13, 32'h0,        8'd4},
    '{2'd1, 8'h11, 32'h00000055, 8'd3},  // R3 second timer
    '{2'd1, 8'h01, 32'h89ABCDEF, 8'd3},  // R3 first timer untouched
    '{2'd0, 8'h07, 32'hFFFFFFFF, 8'd5},
    '{2'd0, 8'h08, 32'hFFFFFFFF, 8'd5},
    '{2'd0, 8'h00, 32'h0000000A, 8'd5},  // up + armed, stopped
    '{2'd2, 8'h81, 32'h0,        8'd5},
    '{2'd1, 8'h81, 32'h0,        8'd5},  // R5 below alarm: no event
    '{2'd1, 8'h00, 32'h0000000A, 8'd6},  // R6 still armed
    '{2'd0, 8'h08, 32'h00000000, 8'd5},  // alarm now below count
    '{2'd2, 8'h81, 32'h0,        8'd5},
    '{2'd1, 8'h81, 32'h00000001, 8'd8},  // R8 raw pending set
    '{2'd1, 8'h82, 32'h00000000, 8'd8},  // R8 masked by enable 0
    '{2'd1, 8'h00, 32'h00000002, 8'd6},  // R6 arm cleared
    '{2'd0, 8'h03, 32'h0,        8'd7},
    '{2'd1, 8'h01, 32'h89ABCDEF, 8'd7},  // R7 no reload when off
    '{2'd0, 8'h83, 32'h00000001, 8'd8},
    '{2'd1, 8'h81, 32'h00000000, 8'd8},  // R8 cleared
    '{2'd0, 8'h00, 32'h0000000A, 8'd6},  // re-arm
    '{2'd2, 8'h81, 32'h0,        8'd6},
    '{2'd1, 8'h81, 32'h00000001, 8'd6},  // R6 one event per arming
    '{2'd0, 8'h83, 32'h00000001, 8'd6},
    '{2'd1, 8'h81, 32'h00000000, 8'd6}   // R6 no refire once disarmed
  };

  task automatic chk(input logic [63:0] got, input logic [63:0] exp, input string tag);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic snap64(input logic [7:0] base, output logic [63:0] v);
    logic [31:0] lo, hi;
    wr(base + 8'h3, 32'h0);
    rd(base + 8'h1, lo);
    rd(base + 8'h2, hi);
    v = {hi, lo};
  endtask

  // start at one edge, stop exactly m edges later, then read the count
  task automatic run_for(input logic [7:0] base, input logic [31:0] ctrl_run,
                         input int m, output logic [63:0] v);
    wr(base, ctrl_run);
    repeat (m - 1) @(negedge clk);
    wr(base, ctrl_run & 32'hFFFF_FFFE);
    snap64(base, v);
  endtask

  task automatic zero_load(input logic [7:0] base, input logic [31:0] lo);
    wr(base + 8'h4, lo);
    wr(base + 8'h5, 32'h0);
    wr(base + 8'h6, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [63:0] v;
    repeat (3) @(negedge clk);
    // reset state
    chk(bus_rdata, 0, "R11 rdata after reset");
    chk(level_irq, 0, "R9 level_irq after reset");
    chk(edge_irq, 0, "R9 edge_irq after reset");
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].kind == 2'd0) wr(VEC[i].addr, VEC[i].data);
      else begin
        rd(VEC[i].addr, r);
        if (VEC[i].kind == 2'd1)
          chk(r, VEC[i].data, $sformatf("R%0d vector %0d", VEC[i].req, i));
      end
    end
    chk(level_irq, 0, "R9 no level without enables");

    // R1 R2: divider 4 counting up for 40 clocks -> 10
    zero_load(8'h10, 32'h0);
    run_for(8'h10, 32'h0004_0003, 40, v);
    chk(v, 10, "R2 divider 4 up count");
    // R2: divider 1 acts as 2
    zero_load(8'h10, 32'h0);
    run_for(8'h10, 32'h0001_0003, 10, v);
    chk(v, 5, "R2 divider 1 means 2");
    // R1: down count with divider 2 from 100 for 20 clocks -> 90
    zero_load(8'h10, 32'd100);
    run_for(8'h10, 32'h0002_0001, 20, v);
    chk(v, 90, "R1 down count");
    // R1: stopped counter holds
    repeat (20) @(negedge clk);
    snap64(8'h10, v);
    chk(v, 90, "R1 hold while stopped");
    // R10: divider change mid-count restarts the prescaler
    zero_load(8'h10, 32'h0);
    wr(8'h10, 32'h0004_0003);
    repeat (6) @(negedge clk);
    wr(8'h10, 32'h0003_0003);
    repeat (2) @(negedge clk);
    wr(8'h10, 32'h0003_0002);
    snap64(8'h10, v);
    chk(v, 2, "R10 prescaler restart on divider change");
    // R2: divider 0 acts as 65536
    zero_load(8'h10, 32'h0);
    run_for(8'h10, 32'h0000_0003, 65536, v);
    chk(v, 1, "R2 divider 0 means 65536");

    // R7 R9: down-count alarm with auto-reload from staged value
    zero_load(8'h10, 32'd10);
    wr(8'h14, 32'd50);            // staged only
    wr(8'h17, 32'd15);
    wr(8'h18, 32'h0);
    wr(8'h80, 32'h2);
    wr(8'h10, 32'h0000_003C);
    chk(edge_irq, 0, "R9 edge not before event");
    @(negedge clk);
    chk(edge_irq, 1, "R9 edge pulse after event");
    chk(level_irq, 1, "R9 level asserted");
    @(negedge clk);
    chk(edge_irq, 0, "R9 edge lasts one cycle");
    chk(level_irq, 1, "R9 level held");
    snap64(8'h10, v);
    chk(v, 50, "R7 auto-reload copies staged value");
    rd(8'h10, r);
    chk(r[3], 0, "R6 arm cleared on event");
    wr(8'h80, 32'h0);
    chk(level_irq, 0, "R8 level masked by enable");
    rd(8'h81, r);
    chk(r, 32'h2, "R8 raw unaffected by mask");
    wr(8'h83, 32'h2);
    rd(8'h81, r);
    chk(r, 0, "R8 cleared by write-one");

    // R5: up-count alarm fires only once count reaches 6 (divider 2)
    wr(8'h80, 32'h1);
    zero_load(8'h00, 32'h0);
    wr(8'h07, 32'd6);
    wr(8'h08, 32'h0);
    wr(8'h00, 32'h0001_001B);
    repeat (12) @(negedge clk);
    chk(level_irq, 0, "R5 no event before reaching alarm");
    @(negedge clk);
    chk(level_irq, 1, "R5 event at alarm in up direction");
    wr(8'h00, 32'h0001_0000);
    wr(8'h83, 32'h1);
    chk(level_irq, 0, "R8 level drops after clear");

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule